// File: doc/BRIEF.md
# DAC Digital Mute Gain Ramper

This block sits in the playback path of an audio DAC and shapes the digital gain seen by the left and right channels whenever software toggles the mute control. It does not jump the gain to silence. It walks a shared ramp level one attenuation step per step-tick pulse, toward full attenuation when mute is set and back to zero extra attenuation when mute is cleared. Each channel's effective attenuation code is the larger of its programmed code and the ramp level. When a ramp finishes, a one-cycle done event is raised: one pulse for a completed ramp down and a different pulse for a completed ramp up. Both pulses are meant to set flags in an interrupt flag register that software polls.

Attenuation codes are GAIN_W bits wide, 5 by default. Code 0 is 0 dB, each code step adds 1 dB of attenuation, and the all-ones code (31) means silence. The two programmed gain registers are applied crossed. A link control makes the left register drive both channels. While the DAC is in standby, a mute change takes effect on the next clock with no ramp and no event. The sample multiply that applies the attenuation is outside this block.

Top module: `dac_mute_ramper`

## Requirements
- R1: While reset is asserted, and after it is released with mute low, both done pulses are 0. Each channel's attenuation equals its routed programmed code, because the ramp level is 0.
- R2: With the link control low, `att_left` takes its value from `gain_rreg` and `att_right` takes its value from `gain_lreg`.
- R3: With the link control high, both `att_left` and `att_right` take their value from `gain_lreg`.
- R4: After mute is set outside standby, each step-tick cycle raises the ramp level by one. Each channel's attenuation is the maximum of its routed code and the ramp level.
- R5: When a ramp down reaches level 31, `ramp_down_done` pulses high for exactly one cycle. The pulse comes in the clock cycle after the step that reached 31.
- R6: After mute is cleared outside standby, each step-tick lowers the level by one. When the level reaches 0, `ramp_up_done` pulses for exactly one cycle in the following clock cycle.
- R7: While standby is high, a mute change moves the level straight to 31 or to 0 on the next clock, and neither done pulse is raised. Asserting standby in the middle of a ramp also ends the ramp with no event.
- R8: A mute change during a ramp reverses the direction from the current level. Only the direction that finally completes raises its done pulse.
- R9: While unmuted and idle, a change to a gain register or to the link control appears at the outputs in the same cycle, with no done pulse.
- R10: With no mute change pending, step-tick pulses change neither output nor raise a done pulse.
- R11: The two done pulses are never high together, and neither is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dac_mute | input | 1 | Digital mute control (1 = muted) |
| dac_standby | input | 1 | DAC standby control (1 = standby, ramp bypassed) |
| gain_lreg | input | GAIN_W | Programmed left gain register code (drives right channel) |
| gain_rreg | input | GAIN_W | Programmed right gain register code (drives left channel) |
| gain_link | input | 1 | When 1, the left register code drives both channels |
| step_tick | input | 1 | One-cycle pulse allowing one ramp step |
| att_left | output | GAIN_W | Effective left-channel attenuation code |
| att_right | output | GAIN_W | Effective right-channel attenuation code |
| ramp_down_done | output | 1 | One-cycle pulse when a ramp to silence completes |
| ramp_up_done | output | 1 | One-cycle pulse when a ramp back to programmed gain completes |

## Verification
The assertions guard properties that hold on every cycle. The ramp level moves by at most one step, and only on a step-tick or in standby. A done pulse appears only at the matching end level, never after a standby cycle, and never on two cycles in a row. A fully muted level forces every channel to silence. The bench is needed for the rest: the crossed and linked routing over every pair of codes, the exact cycle in which each done pulse arrives, and a ramp that reverses part way, which must end with one up pulse and no down pulse. The bench also shows that a standby jump and idle ticks leave the event pulses silent.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

   // Ramp direction follows the mute control.
   typedef enum logic {
      RAMP_RISE = 1'b0,
      RAMP_FALL = 1'b1
   } ramp_dir_e;

   // Completion events of a ramp.
   typedef struct packed {
      logic down;
      logic up;
   } ramp_evt_t;

endpackage

// File: rtl/dmr_gain_route.sv
module dmr_gain_route #(
   parameter int GAIN_W  = 5,
   parameter bit LINK_EN = 1'b1
) (
   input  logic [GAIN_W-1:0] reg_l,
   input  logic [GAIN_W-1:0] reg_r,
   input  logic              link,
   output logic [GAIN_W-1:0] tgt_l,
   output logic [GAIN_W-1:0] tgt_r
);

   // Registers drive the opposite channel.
   assign tgt_r = reg_l;

   generate
      if (LINK_EN) begin : g_link
         assign tgt_l = link ? reg_l : reg_r;
      end else begin : g_nolink
         logic unused_link;
         assign unused_link = link;
         assign tgt_l = reg_r;
      end
   endgenerate

endmodule

// File: rtl/dmr_ramp_ctrl.sv
module dmr_ramp_ctrl
   import dmr_pkg::*;
#(
   parameter int GAIN_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mute,
   input  logic              standby,
   input  logic              tick,
   output logic [GAIN_W-1:0] level,
   output ramp_evt_t         evt
);

   localparam logic [GAIN_W-1:0] FULL = {GAIN_W{1'b1}};
   localparam logic [GAIN_W-1:0] ZERO = '0;

   ramp_dir_e         dir;
   logic              mute_q;
   logic              busy;
   logic              toggled;
   logic [GAIN_W-1:0] end_lvl;
   logic              at_end;

   assign dir     = mute ? RAMP_FALL : RAMP_RISE;
   assign toggled = mute ^ mute_q;
   assign end_lvl = (dir == RAMP_FALL) ? FULL : ZERO;
   assign at_end  = (level == end_lvl);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mute_q <= 1'b0;
         busy   <= 1'b0;
         level  <= ZERO;
         evt    <= '0;
      end else begin
         mute_q <= mute;
         evt    <= '0;
         if (standby) begin
            level <= end_lvl;
            busy  <= 1'b0;
         end else begin
            if (toggled) begin
               busy <= 1'b1;
            end else if (busy && at_end) begin
               busy     <= 1'b0;
               evt.down <= (dir == RAMP_FALL);
               evt.up   <= (dir == RAMP_RISE);
            end
            if (tick && !at_end) begin
               if (dir == RAMP_FALL) level <= level + 1'b1;
               else                  level <= level - 1'b1;
            end
         end
      end
   end

   // R10
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(standby) && !$past(tick)) |-> (level == $past(level)));

   // R4
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(standby) |-> ((level == $past(level)) ||
                           (level == $past(level) + 1'b1) ||
                           (level == $past(level) - 1'b1)));

   // R7
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(standby) |-> (evt == '0));

   // R5
   down_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.down |-> (level == FULL));

   // R6
   up_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.up |-> (level == ZERO));

   // R11
   evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> (evt == '0));

endmodule

// File: rtl/dmr_floor_apply.sv
module dmr_floor_apply #(
   parameter int GAIN_W = 5,
   parameter int NCH    = 2
) (
   input  logic [NCH-1:0][GAIN_W-1:0] tgt,
   input  logic [GAIN_W-1:0]          level,
   output logic [NCH-1:0][GAIN_W-1:0] att
);

   localparam logic [GAIN_W-1:0] FULL = {GAIN_W{1'b1}};

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign att[c] = (tgt[c] > level) ? tgt[c] : level;

         // R4
         always_comb begin
            mute_floor_chk: assert (level != FULL || att[c] == FULL);
         end
      end
   endgenerate

endmodule

// File: rtl/dac_mute_ramper.sv
module dac_mute_ramper
   import dmr_pkg::*;
#(
   parameter int GAIN_W  = 5,
   parameter bit LINK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dac_mute,
   input  logic              dac_standby,
   input  logic [GAIN_W-1:0] gain_lreg,
   input  logic [GAIN_W-1:0] gain_rreg,
   input  logic              gain_link,
   input  logic              step_tick,
   output logic [GAIN_W-1:0] att_left,
   output logic [GAIN_W-1:0] att_right,
   output logic              ramp_down_done,
   output logic              ramp_up_done
);

   localparam int NCH = 2;
   localparam int CH_L = 0;
   localparam int CH_R = 1;

   generate
      if (GAIN_W < 2 || GAIN_W > 8) begin : g_bad_width
         $error("dac_mute_ramper: GAIN_W must lie in 2..8");
      end
   endgenerate

   logic [GAIN_W-1:0]          tgt_l;
   logic [GAIN_W-1:0]          tgt_r;
   logic [GAIN_W-1:0]          level;
   ramp_evt_t                  evt;
   logic [NCH-1:0][GAIN_W-1:0] tgt_vec;
   logic [NCH-1:0][GAIN_W-1:0] att_vec;

   dmr_gain_route #(.GAIN_W(GAIN_W), .LINK_EN(LINK_EN)) u_route (
      .reg_l (gain_lreg),
      .reg_r (gain_rreg),
      .link  (gain_link),
      .tgt_l (tgt_l),
      .tgt_r (tgt_r)
   );

   dmr_ramp_ctrl #(.GAIN_W(GAIN_W)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .mute    (dac_mute),
      .standby (dac_standby),
      .tick    (step_tick),
      .level   (level),
      .evt     (evt)
   );

   assign tgt_vec[CH_L] = tgt_l;
   assign tgt_vec[CH_R] = tgt_r;

   dmr_floor_apply #(.GAIN_W(GAIN_W), .NCH(NCH)) u_floor (
      .tgt   (tgt_vec),
      .level (level),
      .att   (att_vec)
   );

   assign att_left       = att_vec[CH_L];
   assign att_right      = att_vec[CH_R];
   assign ramp_down_done = evt.down;
   assign ramp_up_done   = evt.up;

   // R11
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ramp_down_done && ramp_up_done));

   // R5
   down_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_down_done |-> (att_left == {GAIN_W{1'b1}} && att_right == {GAIN_W{1'b1}}));

endmodule

// File: tb/tb_dac_mute_ramper.sv
`timescale 1ns/1ps
module tb_dac_mute_ramper;

   localparam int W    = 5;
   localparam int FULL = 31;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dac_mute = 1'b0;
   logic         dac_standby = 1'b0;
   logic [W-1:0] gain_lreg = '0;
   logic [W-1:0] gain_rreg = '0;
   logic         gain_link = 1'b0;
   logic         step_tick = 1'b0;
   logic [W-1:0] att_left;
   logic [W-1:0] att_right;
   logic         ramp_down_done;
   logic         ramp_up_done;

   int checks = 0;
   int errors = 0;
   int dn_seen = 0;
   int up_seen = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   dac_mute_ramper #(.GAIN_W(W), .LINK_EN(1'b1)) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .dac_mute       (dac_mute),
      .dac_standby    (dac_standby),
      .gain_lreg      (gain_lreg),
      .gain_rreg      (gain_rreg),
      .gain_link      (gain_link),
      .step_tick      (step_tick),
      .att_left       (att_left),
      .att_right      (att_right),
      .ramp_down_done (ramp_down_done),
      .ramp_up_done   (ramp_up_done)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         dn_seen += int'(ramp_down_done);
         up_seen += int'(ramp_up_done);
      end
   end

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick1();
      @(negedge clk) step_tick = 1'b1;
      @(negedge clk) step_tick = 1'b0;
      #1;
   endtask

   task automatic idle1();
      @(negedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset state
      gain_lreg = 5'd3;
      gain_rreg = 5'd7;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 att_left in reset", int'(att_left), 7);
      chk("R1 att_right in reset", int'(att_right), 3);
      chk("R1 no down pulse in reset", int'(ramp_down_done), 0);
      chk("R1 no up pulse in reset", int'(ramp_up_done), 0);
      @(negedge clk) rst_n = 1'b1;
      idle1();
      chk("R1 att_left after reset", int'(att_left), 7);
      chk("R1 att_right after reset", int'(att_right), 3);

      // R2, R3, R9: exhaustive routing sweep while unmuted and idle
      for (int lk = 0; lk < 2; lk++) begin
         for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
               @(negedge clk);
               gain_link = lk[0];
               gain_lreg = a[W-1:0];
               gain_rreg = b[W-1:0];
               #1;
               if (lk == 0) begin
                  chk("R2 crossed left", int'(att_left), b);
                  chk("R2 crossed right", int'(att_right), a);
               end else begin
                  chk("R3 linked left", int'(att_left), a);
                  chk("R3 linked right", int'(att_right), a);
               end
            end
         end
      end
      idle1();
      chk("R9 no down pulse on gain writes", dn_seen, 0);
      chk("R9 no up pulse on gain writes", up_seen, 0);

      // R4, R5: full ramp down, left target 20, right target 5
      @(negedge clk);
      gain_link = 1'b0;
      gain_lreg = 5'd5;
      gain_rreg = 5'd20;
      dac_mute  = 1'b1;
      idle1();
      chk("R4 no step without tick left", int'(att_left), 20);
      chk("R4 no step without tick right", int'(att_right), 5);
      for (int i = 1; i <= FULL; i++) begin
         tick1();
         chk("R4 ramp down left", int'(att_left), imax(20, i));
         chk("R4 ramp down right", int'(att_right), imax(5, i));
         chk("R5 no early down pulse", int'(ramp_down_done), 0);
      end
      idle1();
      chk("R5 down pulse after full", int'(ramp_down_done), 1);
      chk("R11 no up pulse with down", int'(ramp_up_done), 0);
      idle1();
      chk("R5 down pulse single cycle", int'(ramp_down_done), 0);
      chk("R5 one down pulse total", dn_seen, 1);

      // R10: idle ticks while fully muted
      for (int i = 0; i < 3; i++) begin
         tick1();
         chk("R10 idle tick left", int'(att_left), FULL);
         chk("R10 idle tick right", int'(att_right), FULL);
      end
      idle1();
      chk("R10 no extra down pulse", dn_seen, 1);
      chk("R10 no up pulse", up_seen, 0);

      // R6: full ramp up
      @(negedge clk) dac_mute = 1'b0;
      idle1();
      chk("R6 no step without tick", int'(att_left), FULL);
      for (int i = 1; i <= FULL; i++) begin
         tick1();
         chk("R6 ramp up left", int'(att_left), imax(20, FULL - i));
         chk("R6 ramp up right", int'(att_right), imax(5, FULL - i));
         chk("R6 no early up pulse", int'(ramp_up_done), 0);
      end
      idle1();
      chk("R6 up pulse after zero", int'(ramp_up_done), 1);
      idle1();
      chk("R6 up pulse single cycle", int'(ramp_up_done), 0);
      chk("R6 one up pulse total", up_seen, 1);

      // R8: reversal mid-ramp
      dn_seen = 0;
      up_seen = 0;
      @(negedge clk) dac_mute = 1'b1;
      for (int i = 1; i <= 10; i++) tick1();
      chk("R8 level 10 before reversal", int'(att_left), 20);
      chk("R8 level 10 on right", int'(att_right), 10);
      @(negedge clk) dac_mute = 1'b0;
      idle1();
      chk("R8 holds at reversal", int'(att_right), 10);
      for (int i = 1; i <= 10; i++) begin
         tick1();
         chk("R8 reversed ramp right", int'(att_right), imax(5, 10 - i));
      end
      idle1();
      chk("R8 up pulse after reversal", int'(ramp_up_done), 1);
      idle1();
      chk("R8 no down pulse in reversal", dn_seen, 0);
      chk("R8 single up pulse", up_seen, 1);

      // R7: standby bypass
      dn_seen = 0;
      up_seen = 0;
      @(negedge clk);
      dac_standby = 1'b1;
      dac_mute    = 1'b1;
      idle1();
      chk("R7 standby mute jump left", int'(att_left), FULL);
      chk("R7 standby mute jump right", int'(att_right), FULL);
      for (int i = 0; i < 4; i++) idle1();
      @(negedge clk) dac_mute = 1'b0;
      idle1();
      chk("R7 standby unmute jump left", int'(att_left), 20);
      chk("R7 standby unmute jump right", int'(att_right), 5);
      for (int i = 0; i < 4; i++) idle1();
      chk("R7 no down pulse in standby", dn_seen, 0);
      chk("R7 no up pulse in standby", up_seen, 0);

      // R7: standby asserted mid-ramp
      @(negedge clk) dac_standby = 1'b0;
      @(negedge clk) dac_mute = 1'b1;
      for (int i = 1; i <= 8; i++) tick1();
      chk("R7 partial ramp right", int'(att_right), 8);
      @(negedge clk) dac_standby = 1'b1;
      idle1();
      chk("R7 mid-ramp standby jump", int'(att_right), FULL);
      for (int i = 0; i < 4; i++) idle1();
      @(negedge clk) dac_standby = 1'b0;
      for (int i = 0; i < 4; i++) idle1();
      chk("R7 no pulse after mid-ramp standby", dn_seen + up_seen, 0);

      done_flag = 1'b1;
      summary();
      $finish;
   end

endmodule